// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the hard-wired controller for a multicycle load/store processor datapath. Each instruction passes through a short series of phases (fetch, decode, address calculation, memory access, ALU execution, register write-back, branch or jump), one phase per clock. A 4-bit binary phase register holds the current step. Next-state logic picks the following phase from the present phase and the 6-bit opcode held in the instruction register.

The sixteen datapath control lines are a Moore function of the phase. They are produced from registers that load the decode of the next phase, so they change on the same edge as the phase register and always match it. The datapath, the ALU function decode and the branch zero test sit outside this block. The conditional PC write line tells the datapath to apply the zero test.

Top module: `mcu_ctrl_fsm`

## Requirements
- R1: While `rst` is high at a rising edge, the phase becomes 0000 and the outputs take the fetch values of R7 on that edge.
- R2: From phase 0000, 0011 or 0110, the next phase is the present phase plus one.
- R3: From phase 0001, the opcode picks the next phase: 100011 (load) and 101011 (store) go to 0010, 000000 (register op) goes to 0110, 000100 (branch-if-equal) goes to 1000, and 000010 (jump) goes to 1001.
- R4: From phase 0010, load (100011) goes to 0011 and store (101011) goes to 0101.
- R5: Phases 0100, 0101, 0111, 1000 and 1001 always go to 0000, whatever the opcode.
- R6: An opcode not listed in R3 (in phase 0001) or not listed in R4 (in phase 0010) sends the next phase to 0000. Unused codes 1010 to 1111 also lead to 0000.
- R7: In phase 0000: `mem_rd_en`=1, `instr_ld`=1, `mem_addr_src`=0, `alu_a_src`=0, `alu_b_src`=01, `alu_op_sel`=00, `pc_next_src`=00, `pc_wr_en`=1.
- R8: In phase 0001: `alu_a_src`=0, `alu_b_src`=11, `alu_op_sel`=00. In phase 0010: `alu_a_src`=1, `alu_b_src`=10, `alu_op_sel`=00.
- R9: In phase 0011: `mem_rd_en`=1 and `mem_addr_src`=1. In phase 0101: `mem_wr_en`=1 and `mem_addr_src`=1.
- R10: In phase 0100: `rf_wr_en`=1, `rf_dst_sel`=0, `rf_data_sel`=1. In phase 0111: `rf_wr_en`=1, `rf_dst_sel`=1, `rf_data_sel`=0.
- R11: In phase 0110: `alu_a_src`=1, `alu_b_src`=00, `alu_op_sel`=10. In phase 1000: `alu_a_src`=1, `alu_b_src`=00, `alu_op_sel`=01, `pc_wr_if_zero`=1, `pc_next_src`=01. In phase 1001: `pc_wr_en`=1, `pc_next_src`=10.
- R12: Every output not given a value for the current phase in R7 to R11 is 0, including don't-care selects. This also holds for the unused phase codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field from the instruction register |
| phase | output | 4 | Present phase code |
| mem_rd_en | output | 1 | Memory read enable |
| mem_addr_src | output | 1 | Memory address select: 0 program counter, 1 ALU result register |
| instr_ld | output | 1 | Instruction register load |
| mem_wr_en | output | 1 | Memory write enable |
| rf_wr_en | output | 1 | Register file write enable |
| rf_dst_sel | output | 1 | Destination register field select |
| rf_data_sel | output | 1 | Write-back data select: 0 ALU result, 1 memory data |
| alu_op_sel | output | 2 | ALU operation class: 00 add, 01 subtract, 10 function field |
| alu_a_src | output | 1 | ALU first operand: 0 program counter, 1 register A |
| alu_b_src | output | 2 | ALU second operand: 00 register B, 01 constant 4, 10 extended immediate, 11 shifted extended immediate |
| pc_next_src | output | 2 | PC source: 00 ALU, 01 ALU result register, 10 jump target |
| pc_wr_en | output | 1 | Unconditional PC write |
| pc_wr_if_zero | output | 1 | PC write when the datapath zero test holds |

## Verification
The bench targets the two dispatch points with unlisted opcodes. A branch-if-equal opcode arriving in the address phase is one such case. A design that fell through to a stale or incremented phase would then run memory or write-back steps that no instruction asked for. The terminal phases get opcodes that would be valid elsewhere, to catch next-state logic that dispatches where it should return to fetch. Resets arrive in the middle of instructions to confirm that the phase and the registered outputs both snap back to the fetch values on the same edge. If the outputs lagged by a cycle, every output check after a phase change would fail.

// File: rtl/mcu_ctrl_pkg.sv
package mcu_ctrl_pkg;
  localparam int PH_W  = 4;
  localparam int OPC_W = 6;

  typedef enum logic [PH_W-1:0] {
    PH_FETCH  = 4'd0,
    PH_DECODE = 4'd1,
    PH_ADDR   = 4'd2,
    PH_LDRD   = 4'd3,
    PH_LDWB   = 4'd4,
    PH_STWR   = 4'd5,
    PH_EXEC   = 4'd6,
    PH_RWB    = 4'd7,
    PH_BRANCH = 4'd8,
    PH_JUMP   = 4'd9
  } phase_e;

  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;
  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_JMP   = 6'b000010;

  typedef struct packed {
    logic       mem_rd_en;
    logic       mem_addr_src;
    logic       instr_ld;
    logic       mem_wr_en;
    logic       rf_wr_en;
    logic       rf_dst_sel;
    logic       rf_data_sel;
    logic [1:0] alu_op_sel;
    logic       alu_a_src;
    logic [1:0] alu_b_src;
    logic [1:0] pc_next_src;
    logic       pc_wr_en;
    logic       pc_wr_if_zero;
  } ctl_word_t;
endpackage

// File: rtl/mcu_next_phase.sv
module mcu_next_phase
  import mcu_ctrl_pkg::*;
(
  input  phase_e             cur,
  input  logic [OPC_W-1:0]   opc,
  output phase_e             nxt
);
  always_comb begin
    nxt = PH_FETCH;
    unique case (cur)
      PH_FETCH, PH_LDRD, PH_EXEC: nxt = phase_e'(cur + PH_W'(1));
      PH_DECODE: begin
        if (opc == OPC_LOAD || opc == OPC_STORE) nxt = PH_ADDR;
        else if (opc == OPC_RTYPE)               nxt = PH_EXEC;
        else if (opc == OPC_BEQ)                 nxt = PH_BRANCH;
        else if (opc == OPC_JMP)                 nxt = PH_JUMP;
        else                                     nxt = PH_FETCH;
      end
      PH_ADDR: begin
        if (opc == OPC_LOAD)       nxt = PH_LDRD;
        else if (opc == OPC_STORE) nxt = PH_STWR;
        else                       nxt = PH_FETCH;
      end
      default: nxt = PH_FETCH;
    endcase
  end
endmodule

// File: rtl/mcu_ctl_decode.sv
module mcu_ctl_decode
  import mcu_ctrl_pkg::*;
(
  input  phase_e    ph,
  output ctl_word_t cw
);
  always_comb begin
    cw = '0;
    case (ph)
      PH_FETCH: begin
        cw.mem_rd_en = 1'b1;
        cw.instr_ld  = 1'b1;
        cw.alu_b_src = 2'b01;
        cw.pc_wr_en  = 1'b1;
      end
      PH_DECODE: cw.alu_b_src = 2'b11;
      PH_ADDR: begin
        cw.alu_a_src = 1'b1;
        cw.alu_b_src = 2'b10;
      end
      PH_LDRD: begin
        cw.mem_rd_en    = 1'b1;
        cw.mem_addr_src = 1'b1;
      end
      PH_LDWB: begin
        cw.rf_wr_en    = 1'b1;
        cw.rf_data_sel = 1'b1;
      end
      PH_STWR: begin
        cw.mem_wr_en    = 1'b1;
        cw.mem_addr_src = 1'b1;
      end
      PH_EXEC: begin
        cw.alu_a_src  = 1'b1;
        cw.alu_op_sel = 2'b10;
      end
      PH_RWB: begin
        cw.rf_wr_en   = 1'b1;
        cw.rf_dst_sel = 1'b1;
      end
      PH_BRANCH: begin
        cw.alu_a_src     = 1'b1;
        cw.alu_op_sel    = 2'b01;
        cw.pc_wr_if_zero = 1'b1;
        cw.pc_next_src   = 2'b01;
      end
      PH_JUMP: begin
        cw.pc_wr_en    = 1'b1;
        cw.pc_next_src = 2'b10;
      end
      default: cw = '0;
    endcase
  end
endmodule

// File: rtl/mcu_ctrl_fsm.sv
module mcu_ctrl_fsm
  import mcu_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  output logic [PH_W-1:0]  phase,
  output logic             mem_rd_en,
  output logic             mem_addr_src,
  output logic             instr_ld,
  output logic             mem_wr_en,
  output logic             rf_wr_en,
  output logic             rf_dst_sel,
  output logic             rf_data_sel,
  output logic [1:0]       alu_op_sel,
  output logic             alu_a_src,
  output logic [1:0]       alu_b_src,
  output logic [1:0]       pc_next_src,
  output logic             pc_wr_en,
  output logic             pc_wr_if_zero
);
  phase_e    phase_q, phase_d, phase_ld;
  ctl_word_t ctl_q, ctl_d;

  mcu_next_phase u_next (.cur(phase_q), .opc(opcode), .nxt(phase_d));

  assign phase_ld = rst ? PH_FETCH : phase_d;

  // Outputs are decoded from the phase about to be loaded, so they stay aligned with it.
  mcu_ctl_decode u_dec (.ph(phase_ld), .cw(ctl_d));

  always_ff @(posedge clk) begin
    phase_q <= phase_ld;
    ctl_q   <= ctl_d;
  end

  assign phase         = phase_q;
  assign mem_rd_en     = ctl_q.mem_rd_en;
  assign mem_addr_src  = ctl_q.mem_addr_src;
  assign instr_ld      = ctl_q.instr_ld;
  assign mem_wr_en     = ctl_q.mem_wr_en;
  assign rf_wr_en      = ctl_q.rf_wr_en;
  assign rf_dst_sel    = ctl_q.rf_dst_sel;
  assign rf_data_sel   = ctl_q.rf_data_sel;
  assign alu_op_sel    = ctl_q.alu_op_sel;
  assign alu_a_src     = ctl_q.alu_a_src;
  assign alu_b_src     = ctl_q.alu_b_src;
  assign pc_next_src   = ctl_q.pc_next_src;
  assign pc_wr_en      = ctl_q.pc_wr_en;
  assign pc_wr_if_zero = ctl_q.pc_wr_if_zero;

  // R2
  fetch_advance_chk: assert property (@(posedge clk) disable iff (rst)
    phase_q == PH_FETCH |=> phase_q == PH_DECODE);
  // R3
  rtype_dispatch_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_DECODE && opcode == OPC_RTYPE) |=> phase_q == PH_EXEC);
  // R5
  terminal_return_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_LDWB || phase_q == PH_STWR || phase_q == PH_RWB ||
     phase_q == PH_BRANCH || phase_q == PH_JUMP) |=> phase_q == PH_FETCH);
  // R9
  store_addr_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> (mem_addr_src && !mem_rd_en));
  // R12
  single_pc_write_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({pc_wr_en, pc_wr_if_zero}) <= 1);
  // R1
  reset_fetch_chk: assert property (@(posedge clk)
    rst |=> (phase_q == PH_FETCH && instr_ld && pc_wr_en));
endmodule

// File: tb/mcu_ctrl_fsm_tb.sv
module mcu_ctrl_fsm_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'd0;
  logic [3:0] phase;
  logic mem_rd_en, mem_addr_src, instr_ld, mem_wr_en, rf_wr_en, rf_dst_sel, rf_data_sel;
  logic alu_a_src, pc_wr_en, pc_wr_if_zero;
  logic [1:0] alu_op_sel, alu_b_src, pc_next_src;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [3:0] m_ph = 4'd0;

  always #2 clk = ~clk;

  mcu_ctrl_fsm u_dut (
    .clk(clk), .rst(rst), .opcode(opcode), .phase(phase),
    .mem_rd_en(mem_rd_en), .mem_addr_src(mem_addr_src), .instr_ld(instr_ld),
    .mem_wr_en(mem_wr_en), .rf_wr_en(rf_wr_en), .rf_dst_sel(rf_dst_sel),
    .rf_data_sel(rf_data_sel), .alu_op_sel(alu_op_sel), .alu_a_src(alu_a_src),
    .alu_b_src(alu_b_src), .pc_next_src(pc_next_src), .pc_wr_en(pc_wr_en),
    .pc_wr_if_zero(pc_wr_if_zero)
  );

  function automatic logic [3:0] ref_next(input logic [3:0] s, input logic [5:0] o);
    case (s)
      4'd0, 4'd3, 4'd6: return s + 4'd1;
      4'd1: case (o)
        6'b100011, 6'b101011: return 4'd2;
        6'b000000: return 4'd6;
        6'b000100: return 4'd8;
        6'b000010: return 4'd9;
        default:   return 4'd0;
      endcase
      4'd2: case (o)
        6'b100011: return 4'd3;
        6'b101011: return 4'd5;
        default:   return 4'd0;
      endcase
      default: return 4'd0;
    endcase
  endfunction

  // order: rd, addr, ild, wr, rfw, dst, data, aop[2], a, b[2], psrc[2], pcw, pcz
  function automatic logic [15:0] ref_out(input logic [3:0] s);
    logic mr = 0, ma = 0, il = 0, mw = 0, rw = 0, rd = 0, rdat = 0, aa = 0, pw = 0, pz = 0;
    logic [1:0] aop = 0, ab = 0, ps = 0;
    case (s)
      4'd0: begin mr = 1; il = 1; ab = 2'b01; pw = 1; end
      4'd1: ab = 2'b11;
      4'd2: begin aa = 1; ab = 2'b10; end
      4'd3: begin mr = 1; ma = 1; end
      4'd4: begin rw = 1; rdat = 1; end
      4'd5: begin mw = 1; ma = 1; end
      4'd6: begin aa = 1; aop = 2'b10; end
      4'd7: begin rw = 1; rd = 1; end
      4'd8: begin aa = 1; aop = 2'b01; pz = 1; ps = 2'b01; end
      4'd9: begin pw = 1; ps = 2'b10; end
      default: ;
    endcase
    return {mr, ma, il, mw, rw, rd, rdat, aop, aa, ab, ps, pw, pz};
  endfunction

  function automatic string out_req(input logic [3:0] s);
    case (s)
      4'd0: return "R7,R12";
      4'd1, 4'd2: return "R8,R12";
      4'd3, 4'd5: return "R9,R12";
      4'd4, 4'd7: return "R10,R12";
      default: return "R11,R12";
    endcase
  endfunction

  function automatic string ph_req(input logic r, input logic [3:0] p, input logic [5:0] o);
    if (r) return "R1";
    case (p)
      4'd0, 4'd3, 4'd6: return "R2";
      4'd1: return (ref_next(p, o) == 4'd0) ? "R6" : "R3";
      4'd2: return (ref_next(p, o) == 4'd0) ? "R6" : "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic cycle(input logic r, input logic [5:0] o);
    logic [3:0] prev;
    logic [15:0] got;
    logic [15:0] exp;
    rst = r;
    opcode = o;
    @(posedge clk);
    prev = m_ph;
    m_ph = r ? 4'd0 : ref_next(m_ph, o);
    @(negedge clk);
    checks++;
    if (phase !== m_ph) begin
      errors++;
      $display("FAIL %s phase from %0d op %b: got %0d exp %0d", ph_req(r, prev, o), prev, o, phase, m_ph);
    end
    got = {mem_rd_en, mem_addr_src, instr_ld, mem_wr_en, rf_wr_en, rf_dst_sel, rf_data_sel,
           alu_op_sel, alu_a_src, alu_b_src, pc_next_src, pc_wr_en, pc_wr_if_zero};
    exp = ref_out(m_ph);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s outputs in phase %0d: got %b exp %b", r ? "R1" : out_req(m_ph), m_ph, got, exp);
    end
  endtask

  function automatic logic [5:0] pick_op();
    logic [5:0] list [5] = '{6'b100011, 6'b101011, 6'b000000, 6'b000100, 6'b000010};
    if ($urandom % 10 < 8) return list[$urandom % 5];
    return 6'($urandom);
  endfunction

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    // R1: reset state
    cycle(1'b1, 6'b111111);
    cycle(1'b1, 6'b000000);
    // R2, R3, R4, R9, R10: full load instruction
    cycle(0, 6'b100011); cycle(0, 6'b100011); cycle(0, 6'b100011);
    cycle(0, 6'b100011); cycle(0, 6'b100011);
    // R4, R9: store
    cycle(0, 6'b101011); cycle(0, 6'b101011); cycle(0, 6'b101011); cycle(0, 6'b101011);
    // R6: unlisted opcode in decode
    cycle(0, 6'b111111); cycle(0, 6'b111111);
    // R6: branch opcode arriving in the address phase
    cycle(0, 6'b100011); cycle(0, 6'b100011); cycle(0, 6'b000100);
    // R5: terminal phase with a valid opcode present; R11 branch and jump
    cycle(0, 6'b000100); cycle(0, 6'b000100); cycle(0, 6'b100011);
    cycle(0, 6'b000010); cycle(0, 6'b000010); cycle(0, 6'b000010);
    // R1: reset mid-instruction
    cycle(0, 6'b000000); cycle(0, 6'b000000); cycle(1'b1, 6'b000000);
    // random mix with occasional resets
    for (int i = 0; i < 3000; i++) begin
      cycle(($urandom % 100) == 0, pick_op());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule